// File: doc/BRIEF.md
# UART Receive Status Flag Controller

This block keeps the receive-side status flags of a serial receiver and decides when the receive data buffer is loaded. A separate receive shifter reports each finished character with a one-cycle strobe. The strobe carries the character's data and three error qualifiers: noise, framing and parity. A line monitor reports an idle line with its own strobe. The bus side of the chip reports three kinds of access as one-cycle strobes: a status read, a data read, and a write to a second status register that carries a clear bit for the edge flag.

The block raises a flag for each of these conditions: data full, overrun, noise, framing, parity, idle line, and an active edge on the serial input. The serial input is asynchronous, so it passes through a synchronizer, and a high-to-low transition counts as the active edge. Most flags are cleared by a two-step handshake: a status read while the flag is set, followed by a data read. The edge flag is the exception and is cleared by writing a one.

Two state machines carry the sequencing. The clear sequencer has two states. CS_WAIT waits for a status read that sees at least one flag set. That read moves it to CS_ARMED and records which flags were set. In CS_ARMED, a data read clears exactly the recorded flags and returns the machine to CS_WAIT. A status read in CS_ARMED records the flags again. The idle machine has three states. IDL_WAIT_CHAR goes to IDL_ARMED when a character sets data full. IDL_ARMED goes to IDL_FLAGGED on an idle strobe. IDL_FLAGGED goes back to IDL_WAIT_CHAR when the handshake clears the idle flag, or to IDL_ARMED if a character sets data full in that same cycle.

Top module: `uart_rx_status`

## Requirements
- R1: A character strobe while the full flag is clear loads `char_data` into `rx_data`. In the same cycle it pulses `buf_load`. The full flag reads 1 from the next cycle.
- R2: The noise, framing and parity flags are set in the same cycle as the full flag, each only when the matching qualifier is 1 on the character that sets full.
- R3: A character strobe while the full flag is set sets the overrun flag. `rx_data` keeps its old value, no load pulse is given, and noise, framing and parity are not set.
- R4: A status read while any flag (full, overrun, noise, framing, parity, idle) is set, followed by a data read, clears exactly the flags that were set at that status read.
- R5: A data read with no armed status read has no effect. A status read while no flag is set does not arm the clear.
- R6: The idle flag is set by an idle strobe only if a character has set the full flag since reset or since the idle flag was last cleared. Repeated idle strobes after a clear leave it at 0.
- R7: The serial input passes through a two-flop synchronizer. A high-to-low transition then sets the edge flag, but only while `rx_enable` is 1. A low-to-high transition never sets it.
- R8: A write strobe with `stat2_clr_edge` = 1 clears the edge flag. With `stat2_clr_edge` = 0 the write leaves the flag unchanged.
- R9: When a set event and a clear for the same flag fall in the same cycle, the flag ends up set.
- R10: After reset all flags are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; gates edge detection |
| rxd_async | input | 1 | Raw serial input, idle high |
| char_done | input | 1 | Shifter finished a character (one-cycle strobe) |
| char_noise | input | 1 | Noise seen on the finishing character |
| char_frame | input | 1 | Framing error on the finishing character |
| char_parity | input | 1 | Parity error on the finishing character |
| char_data | input | DW | Data of the finishing character |
| idle_detect | input | 1 | Idle line seen (strobe) |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| stat2_wr | input | 1 | Second status register write strobe |
| stat2_clr_edge | input | 1 | Write data bit that clears the edge flag |
| flag_full | output | 1 | Receive data full |
| flag_overrun | output | 1 | Overrun |
| flag_noise | output | 1 | Noise |
| flag_frame | output | 1 | Framing error |
| flag_parity | output | 1 | Parity error |
| flag_idle | output | 1 | Idle line |
| flag_edge | output | 1 | Active edge seen on the serial input |
| buf_load | output | 1 | Pulse that loads the receive data buffer |
| rx_data | output | DW | Receive data buffer |

## Verification
Two pairs of events can meet in one cycle.

The first pair is a write-one-to-clear of the edge flag and a new falling edge. The bench sets up this collision by lowering the serial input and then issuing the clear write exactly two clock edges later, once the edge has passed through the synchronizer. The edge flag must still read 1 after that write.

The second pair is the data read that completes a handshake and a new character strobe. The bench arms the handshake with full and overrun both set, then asserts the data read together with a character strobe. It then checks three things: full clears, overrun stays set, and the buffer keeps its old value.

// File: rtl/rxs_pkg.sv
`timescale 1ns/1ps
package rxs_pkg;

    // Clear-handshake sequencer states
    typedef enum logic [0:0] {
        CS_WAIT  = 1'b0,
        CS_ARMED = 1'b1
    } clr_state_e;

    // Idle-line flag states
    typedef enum logic [1:0] {
        IDL_WAIT_CHAR = 2'd0,
        IDL_ARMED     = 2'd1,
        IDL_FLAGGED   = 2'd2
    } idle_state_e;

    // Bit positions inside the handshake-cleared status vector
    localparam int FL_FULL   = 0;
    localparam int FL_OVR    = 1;
    localparam int FL_NOISE  = 2;
    localparam int FL_FRAME  = 3;
    localparam int FL_PARITY = 4;
    localparam int FL_IDLE   = 5;
    localparam int FL_COUNT  = 6;

endpackage

// File: rtl/rxs_sync_edge.sv
`timescale 1ns/1ps
// Synchronizes the serial input and flags a high-to-low transition.
module rxs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_async,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rxd_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[LAST-1:0], rxd_async};
            end
        end
    endgenerate

    // Resets high so that an idle-high line gives no spurious edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[LAST];
    end

    assign fall_o = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/rxs_flag_bit.sv
`timescale 1ns/1ps
// One sticky status flag; a set in the same cycle as a clear wins.
module rxs_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d;

    always_comb begin
        q_d = q_o;
        if (clr_i) q_d = 1'b0;
        if (set_i) q_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= q_d;
    end
endmodule

// File: rtl/rxs_clear_seq.sv
`timescale 1ns/1ps
// Two-step clear: a status read records the set flags, then a data read clears them.
module rxs_clear_seq
    import rxs_pkg::*;
#(
    parameter int NF = FL_COUNT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_rd,
    input  logic          data_rd,
    input  logic [NF-1:0] flags_i,
    output logic [NF-1:0] clr_o
);
    clr_state_e    state_q, state_d;
    logic [NF-1:0] mask_q, mask_d;
    logic          any_set;

    assign any_set = |flags_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_WAIT;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    // Outputs: clear pulse
    always_comb begin
        clr_o = '0;
        unique case (state_q)
            CS_WAIT:  clr_o = '0;
            CS_ARMED: if (data_rd) clr_o = mask_q;
            default:  clr_o = '0;
        endcase
    end

    // Next state and record
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        unique case (state_q)
            CS_WAIT: begin
                if (stat_rd && any_set) begin
                    state_d = CS_ARMED;
                    mask_d  = flags_i;
                end
            end
            CS_ARMED: begin
                if (data_rd) begin
                    state_d = CS_WAIT;
                    mask_d  = '0;
                end
                if (stat_rd) begin
                    mask_d  = flags_i & ~clr_o;
                    state_d = (|mask_d) ? CS_ARMED : CS_WAIT;
                end
            end
            default: begin
                state_d = CS_WAIT;
                mask_d  = '0;
            end
        endcase
    end
endmodule

// File: rtl/rxs_idle_fsm.sv
`timescale 1ns/1ps
// Idle flag that can only be set again after a new character has set full.
module rxs_idle_fsm
    import rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic char_set_i,
    input  logic idle_det_i,
    input  logic clr_i,
    output logic flag_o
);
    idle_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDL_WAIT_CHAR;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            IDL_FLAGGED: flag_o = 1'b1;
            default:     flag_o = 1'b0;
        endcase
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDL_WAIT_CHAR: if (char_set_i) state_d = IDL_ARMED;
            IDL_ARMED:     if (idle_det_i) state_d = IDL_FLAGGED;
            IDL_FLAGGED: begin
                if (clr_i) state_d = char_set_i ? IDL_ARMED : IDL_WAIT_CHAR;
            end
            default:       state_d = IDL_WAIT_CHAR;
        endcase
    end
endmodule

// File: rtl/uart_rx_status.sv
`timescale 1ns/1ps
module uart_rx_status
    import rxs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          rxd_async,
    input  logic          char_done,
    input  logic          char_noise,
    input  logic          char_frame,
    input  logic          char_parity,
    input  logic [DW-1:0] char_data,
    input  logic          idle_detect,
    input  logic          stat_rd,
    input  logic          data_rd,
    input  logic          stat2_wr,
    input  logic          stat2_clr_edge,
    output logic          flag_full,
    output logic          flag_overrun,
    output logic          flag_noise,
    output logic          flag_frame,
    output logic          flag_parity,
    output logic          flag_idle,
    output logic          flag_edge,
    output logic          buf_load,
    output logic [DW-1:0] rx_data
);
    logic [FL_COUNT-1:0] stat_v;
    logic [FL_COUNT-1:0] set_v;
    logic [FL_COUNT-1:0] clr_v;
    logic                full_set;
    logic                fall_seen;

    // A character either fills the empty buffer or overruns the full one
    assign full_set = char_done & ~stat_v[FL_FULL];

    always_comb begin
        set_v            = '0;
        set_v[FL_FULL]   = full_set;
        set_v[FL_OVR]    = char_done & stat_v[FL_FULL];
        set_v[FL_NOISE]  = full_set & char_noise;
        set_v[FL_FRAME]  = full_set & char_frame;
        set_v[FL_PARITY] = full_set & char_parity;
    end

    generate
        for (genvar i = 0; i < FL_IDLE; i++) begin : g_flag
            rxs_flag_bit u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_v[i]),
                .clr_i (clr_v[i]),
                .q_o   (stat_v[i])
            );
        end
    endgenerate

    rxs_idle_fsm u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_set_i (full_set),
        .idle_det_i (idle_detect),
        .clr_i      (clr_v[FL_IDLE]),
        .flag_o     (stat_v[FL_IDLE])
    );

    rxs_clear_seq #(.NF(FL_COUNT)) u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .flags_i (stat_v),
        .clr_o   (clr_v)
    );

    rxs_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd_async (rxd_async),
        .fall_o    (fall_seen)
    );

    rxs_flag_bit u_edge_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fall_seen & rx_enable),
        .clr_i (stat2_wr & stat2_clr_edge),
        .q_o   (flag_edge)
    );

    // Receive data buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_data <= '0;
        else if (full_set) rx_data <= char_data;
    end

    assign buf_load     = full_set;
    assign flag_full    = stat_v[FL_FULL];
    assign flag_overrun = stat_v[FL_OVR];
    assign flag_noise   = stat_v[FL_NOISE];
    assign flag_frame   = stat_v[FL_FRAME];
    assign flag_parity  = stat_v[FL_PARITY];
    assign flag_idle    = stat_v[FL_IDLE];
endmodule

// File: rtl/rxs_checker.sv
`timescale 1ns/1ps
module rxs_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_enable,
    input logic          char_done,
    input logic [DW-1:0] char_data,
    input logic          idle_detect,
    input logic          stat2_wr,
    input logic          stat2_clr_edge,
    input logic          flag_full,
    input logic          flag_overrun,
    input logic          flag_noise,
    input logic          flag_idle,
    input logic          flag_edge,
    input logic [DW-1:0] rx_data
);
    // Tracks whether a character has set full since the idle flag was last seen set
    logic char_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      char_seen_q <= 1'b0;
        else if (char_done && !flag_full) char_seen_q <= 1'b1;
        else if (flag_idle)              char_seen_q <= 1'b0;
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !flag_full) |=> (flag_full && rx_data == $past(char_data)));

    assert_overrun_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && flag_full) |=> (flag_overrun && $stable(rx_data)));

    assert_overrun_no_noise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && flag_full && !flag_noise) |=> !flag_noise);

    assert_idle_needs_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_idle && !char_seen_q) |=> !flag_idle);

    assert_edge_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !flag_edge) |=> !flag_edge);

    assert_edge_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_edge && !rx_enable && stat2_wr && stat2_clr_edge) |=> !flag_edge);

    // Unused here, kept visible for completeness of the idle relation
    logic unused_idle;
    assign unused_idle = idle_detect;
endmodule

bind uart_rx_status rxs_checker #(.DW(DW)) u_rxs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_enable      (rx_enable),
    .char_done      (char_done),
    .char_data      (char_data),
    .idle_detect    (idle_detect),
    .stat2_wr       (stat2_wr),
    .stat2_clr_edge (stat2_clr_edge),
    .flag_full      (flag_full),
    .flag_overrun   (flag_overrun),
    .flag_noise     (flag_noise),
    .flag_idle      (flag_idle),
    .flag_edge      (flag_edge),
    .rx_data        (rx_data)
);

// File: tb/test_uart_rx_status.sv
`timescale 1ns/1ps
module test_uart_rx_status;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_enable = 1'b0;
    logic          rxd_async = 1'b1;
    logic          char_done = 1'b0;
    logic          char_noise = 1'b0;
    logic          char_frame = 1'b0;
    logic          char_parity = 1'b0;
    logic [DW-1:0] char_data = '0;
    logic          idle_detect = 1'b0;
    logic          stat_rd = 1'b0;
    logic          data_rd = 1'b0;
    logic          stat2_wr = 1'b0;
    logic          stat2_clr_edge = 1'b0;
    logic          flag_full, flag_overrun, flag_noise, flag_frame, flag_parity;
    logic          flag_idle, flag_edge, buf_load;
    logic [DW-1:0] rx_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_status #(.DW(DW)) i_uart_rx_status (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rxd_async(rxd_async),
        .char_done(char_done), .char_noise(char_noise), .char_frame(char_frame),
        .char_parity(char_parity), .char_data(char_data), .idle_detect(idle_detect),
        .stat_rd(stat_rd), .data_rd(data_rd), .stat2_wr(stat2_wr),
        .stat2_clr_edge(stat2_clr_edge), .flag_full(flag_full),
        .flag_overrun(flag_overrun), .flag_noise(flag_noise), .flag_frame(flag_frame),
        .flag_parity(flag_parity), .flag_idle(flag_idle), .flag_edge(flag_edge),
        .buf_load(buf_load), .rx_data(rx_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_char(input logic [DW-1:0] d, input logic n, input logic f, input logic p);
        char_done = 1'b1; char_data = d; char_noise = n; char_frame = f; char_parity = p;
        step();
        char_done = 1'b0; char_noise = 1'b0; char_frame = 1'b0; char_parity = 1'b0;
    endtask

    task automatic read_status();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    task automatic read_data();
        data_rd = 1'b1; step(); data_rd = 1'b0;
    endtask

    task automatic write_stat2(input logic bitv);
        stat2_wr = 1'b1; stat2_clr_edge = bitv; step(); stat2_wr = 1'b0; stat2_clr_edge = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 full", flag_full, 0);
        check("R10 overrun", flag_overrun, 0);
        check("R10 errors", {flag_noise, flag_frame, flag_parity}, 0);
        check("R10 idle/edge", {flag_idle, flag_edge}, 0);
        check("R10 data", rx_data, 0);
    endtask

    task automatic t_load_clear();
        char_done = 1'b1; char_data = 8'hA5;
        #1 check("R1 load pulse", buf_load, 1);
        step(); char_done = 1'b0;
        check("R1 full", flag_full, 1);
        check("R1 data", rx_data, 8'hA5);
        read_data();
        check("R5 lone data read", flag_full, 1);
        read_status(); read_data();
        check("R4 full cleared", flag_full, 0);
    endtask

    task automatic t_status_empty();
        read_status();
        send_char(8'h3C, 0, 0, 0);
        read_data();
        check("R5 unarmed status read", flag_full, 1);
        check("R5 data kept", rx_data, 8'h3C);
        read_status(); read_data();
        check("R4 clear after rearm", flag_full, 0);
    endtask

    task automatic t_errors();
        send_char(8'h11, 1, 1, 0);
        check("R2 noise/frame/parity", {flag_noise, flag_frame, flag_parity}, 3'b110);
        read_status(); read_data();
        check("R4 errors cleared", {flag_full, flag_noise, flag_frame, flag_parity}, 0);
        send_char(8'h12, 0, 0, 1);
        check("R2 parity only", {flag_noise, flag_frame, flag_parity}, 3'b001);
        read_status(); read_data();
    endtask

    task automatic t_overrun();
        send_char(8'h22, 0, 0, 0);
        char_done = 1'b1; char_data = 8'h33; char_noise = 1'b1; char_frame = 1'b1; char_parity = 1'b1;
        #1 check("R3 no load pulse", buf_load, 0);
        step();
        char_done = 1'b0; char_noise = 1'b0; char_frame = 1'b0; char_parity = 1'b0;
        check("R3 overrun", flag_overrun, 1);
        check("R3 data kept", rx_data, 8'h22);
        check("R3 no errors", {flag_noise, flag_frame, flag_parity}, 0);
        // Collision: data read completing the clear together with a new character
        read_status();
        data_rd = 1'b1; char_done = 1'b1; char_data = 8'h44;
        step();
        data_rd = 1'b0; char_done = 1'b0;
        check("R9 overrun set wins", flag_overrun, 1);
        check("R4 full cleared", flag_full, 0);
        check("R3 data kept on collision", rx_data, 8'h22);
        read_status(); read_data();
        check("R4 overrun cleared", flag_overrun, 0);
    endtask

    task automatic t_idle();
        idle_detect = 1'b1; step(); idle_detect = 1'b0;
        check("R6 idle set after char", flag_idle, 1);
        read_status(); read_data();
        check("R4 idle cleared", flag_idle, 0);
        for (int k = 0; k < 20; k++) begin
            idle_detect = 1'b1; step(); idle_detect = 1'b0; step();
        end
        check("R6 long idle no reset", flag_idle, 0);
        send_char(8'h55, 0, 0, 0);
        idle_detect = 1'b1; step(); idle_detect = 1'b0;
        check("R6 idle rearmed by char", flag_idle, 1);
        read_status(); read_data();
        check("R4 idle and full cleared", {flag_idle, flag_full}, 0);
    endtask

    task automatic t_edge();
        rx_enable = 1'b0; rxd_async = 1'b0; step(4);
        check("R7 disabled edge ignored", flag_edge, 0);
        rxd_async = 1'b1; step(4);
        rx_enable = 1'b1; step(2);
        check("R7 no edge on enable", flag_edge, 0);
        rxd_async = 1'b0; step(4);
        check("R7 falling edge sets", flag_edge, 1);
        write_stat2(1'b0);
        check("R8 write zero keeps", flag_edge, 1);
        write_stat2(1'b1);
        check("R8 write one clears", flag_edge, 0);
        rxd_async = 1'b1; step(4);
        check("R7 rising edge ignored", flag_edge, 0);
        // Set the flag, then collide a new falling edge with the clear write
        rxd_async = 1'b0; step(4);
        rxd_async = 1'b1; step(4);
        check("R7 flag before collision", flag_edge, 1);
        rxd_async = 1'b0; step(2);
        write_stat2(1'b1);
        check("R9 edge set wins", flag_edge, 1);
        write_stat2(1'b1);
        check("R8 clear after collision", flag_edge, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_load_clear();
        t_status_empty();
        t_errors();
        t_overrun();
        t_idle();
        t_edge();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule